// File: doc/BRIEF.md
# Management Bus Master Controller

This block is a management-bus master that reaches PHY registers over a two-wire serial link. It generates the MDC clock from the system clock and shifts frames out on MDIO. While a read frame's turnaround and data bits are on the wire, it releases the MDIO output enable and samples the PHY's reply. Software controls it through four 32-bit words on a simple register bus.

A transaction is launched as a side effect of a register write:

- A write to the data word sends a write frame.
- A control write with its read bit set sends a read frame.
- In Clause 45 mode only, a write to the address word sends an address frame.

One configuration bit chooses between Clause 22 and Clause 45 framing. Another bit leaves out the preamble. A 9-bit divider sets the MDC rate.

Software polls the busy flag until it drops. After a read, it then fetches the data word and checks the read-error flag.

Top module: `mgmt_bus_master`

## Requirements
- R1: After reset, the status word (word 12) reads 0x0000_0280: divider 5, all flags clear. The control, data and address words read 0.
- R2: Register words are 12, 13, 14 and 15.
  - Word 12 (status) holds: busy at bit 0 (read only), read error at bit 1 (read only), preamble skip at bit 5, Clause 45 select at bit 6, and the divider at bits 15:7.
  - Word 13 (control) holds the device address at bits 4:0, the PHY address at bits 9:5, and a read-launch bit at bit 15 that reads back as 0.
  - Word 14 is the data word. Word 15 is the address word, 16 bits wide.
- R3: Writing the data word sends a write frame and sets busy until the frame ends. The frame is 32 ones, then start 01, opcode 01, PHY address, device address, turnaround 10, and then the 16 data bits. Every field goes out MSB first.
- R4: With Clause 45 select set, writing the address word sends an address frame whose payload is the address word. With Clause 45 select clear, the write only stores the value and busy stays 0.
- R5: A control write with bit 15 set sends a read frame to the PHY and device addresses carried in that same write.
  - MDIO output enable is low from the first turnaround bit to the end of the frame.
  - The 16 bits sampled during the data phase are stored MSB first in the data word when busy drops.
- R6: The read-error flag is set when MDIO samples high in the second turnaround bit of a read. The next frame start clears it.
- R7: While busy, MDC has a period of 2·d+1 clocks: low for d+1 clocks, then high for d clocks, starting low.
  - d is the divider field, except that values below 5 act as 5.
  - MDC is low when the block is idle.
  - A frame lasts (number of bits)·(2·d+1) clocks.
- R8: MDIO output changes only at MDC falling edges or at a frame start. Read bits are sampled at MDC rising edges.
- R9: With preamble skip set, a frame has 32 bits (32 MDC pulses). Otherwise it has 64 bits.
- R10: While busy, writes to any register are ignored: no field changes and no frame is launched.
- R11: Clause 45 frames use start 00 and opcode 00 for address, 01 for write and 11 for read. Clause 22 reads use start 01 and opcode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output to the pad |
| mdio_oe_o | output | 1 | MDIO output enable |

## Verification
Two functions can collide in one cycle: a register write accepted on the bus, and a frame in flight. The bench provokes this by issuing writes to control (with the read bit set), data and status while busy is high, and by reading status in the middle of a frame. A cycle-accurate behavioural model in the bench judges every clock, comparing MDC, output enable and driven MDIO. Afterwards, readback confirms that no field changed and no second frame was launched. A second collision is a new frame starting while an old read error is pending: the flag must clear at the start rather than at the end of the frame.

// File: rtl/mgmt_bus_pkg.sv
package mgmt_bus_pkg;
  typedef enum logic [1:0] {FK_ADDR, FK_WRITE, FK_READ} frame_kind_e;

  function automatic logic [31:0] build_frame(logic c45, frame_kind_e kind,
                                              logic [4:0] port, logic [4:0] dev,
                                              logic [15:0] payload);
    logic [1:0] st, op, ta;
    logic [15:0] pl;
    st = c45 ? 2'b00 : 2'b01;
    unique case (kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      default:  op = c45 ? 2'b11 : 2'b10;
    endcase
    ta = (kind == FK_READ) ? 2'b11 : 2'b10;
    pl = (kind == FK_READ) ? 16'hFFFF : payload;
    return {st, op, port, dev, ta, pl};
  endfunction
endpackage

// File: rtl/mgmt_mdc_gen.sv
module mgmt_mdc_gen #(
  parameter int DIV_W   = 9,
  parameter int DIV_MIN = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W:0]   cnt_q;
  logic [DIV_W-1:0] div_eff;
  logic             mdc_q;

  assign div_eff = (div_i < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : div_i;
  assign rise_o  = run_i && (cnt_q == {1'b0, div_eff});
  assign fall_o  = run_i && (cnt_q == {div_eff, 1'b0});
  assign mdc_o   = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i || fall_o) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (rise_o) mdc_q <= 1'b1;
    end
  end

  // rising strobe only while the clock is still low
  p_rise_from_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> !mdc_o);
endmodule

// File: rtl/mgmt_frame_shifter.sv
module mgmt_frame_shifter #(
  parameter int PRE_W  = 32,
  parameter int FR_W   = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FR_W-1:0]   frame_i,
  input  logic              rd_i,
  input  logic              skip_pre_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              busy_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rderr_o,
  output logic              done_o
);
  localparam int TOT     = PRE_W + FR_W;
  localparam int IDX_W   = $clog2(TOT);
  localparam int TA_IDX  = TOT - DATA_W - 2;
  localparam int ERR_IDX = TA_IDX + 1;

  logic [TOT-1:0]    sh_q;
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q, rd_q, err_q;
  logic [DATA_W-1:0] rv_q;

  assign busy_o  = busy_q;
  assign mdo_o   = sh_q[TOT-1];
  assign oe_o    = busy_q && !(rd_q && idx_q >= IDX_W'(TA_IDX));
  assign rdata_o = rv_q;
  assign rderr_o = err_q;
  assign done_o  = busy_q && fall_i && (idx_q == IDX_W'(TOT-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      rv_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        sh_q   <= skip_pre_i ? {frame_i, {PRE_W{1'b0}}} : {{PRE_W{1'b1}}, frame_i};
        idx_q  <= skip_pre_i ? IDX_W'(PRE_W) : '0;
        busy_q <= 1'b1;
        rd_q   <= rd_i;
        err_q  <= 1'b0;
        rv_q   <= '0;
      end
    end else if (fall_i) begin
      if (done_o) busy_q <= 1'b0;
      else begin
        idx_q <= idx_q + 1'b1;
        sh_q  <= sh_q << 1;
      end
    end else if (rise_i && rd_q) begin
      if (idx_q == IDX_W'(ERR_IDX) && mdio_i) err_q <= 1'b1;
      if (idx_q > IDX_W'(ERR_IDX)) rv_q <= {rv_q[DATA_W-2:0], mdio_i};
    end
  end

  p_start_clears_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_q) |=> !rderr_o);
  p_err_only_on_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> rd_q);
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_bus_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DIV_W     = 9,
  parameter int DIV_MIN   = 5,
  parameter int DIV_RST   = 5,
  parameter int STAT_WORD = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          mdc_o,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o
);
  localparam int CTRL_WORD = STAT_WORD + 1;
  localparam int DATA_WORD = STAT_WORD + 2;
  localparam int ADDR_WORD = STAT_WORD + 3;
  localparam int RD_BIT    = 15;

  logic             pre_skip_q, c45_q;
  logic [DIV_W-1:0] div_q;
  logic [4:0]       dev_q, port_q;
  logic [15:0]      data_q, areg_q;

  logic busy, rise, fall, done, rderr;
  logic [15:0] rd_word;
  logic wr_ok, hit_stat, hit_ctrl, hit_data, hit_addr;
  logic start_wr, start_rd, start_ad, start;
  frame_kind_e kind;
  logic [4:0]  f_port, f_dev;
  logic [31:0] frame;

  assign wr_ok    = req_i && we_i && !busy;
  assign hit_stat = addr_i == AW'(STAT_WORD);
  assign hit_ctrl = addr_i == AW'(CTRL_WORD);
  assign hit_data = addr_i == AW'(DATA_WORD);
  assign hit_addr = addr_i == AW'(ADDR_WORD);
  assign start_wr = wr_ok && hit_data;
  assign start_rd = wr_ok && hit_ctrl && wdata_i[RD_BIT];
  assign start_ad = wr_ok && hit_addr && c45_q;
  assign start    = start_wr || start_rd || start_ad;

  always_comb begin
    kind = FK_WRITE;
    if (start_rd) kind = FK_READ;
    else if (start_ad) kind = FK_ADDR;
  end

  // a read launch uses the addresses carried in the same control write
  assign f_port = hit_ctrl ? wdata_i[9:5] : port_q;
  assign f_dev  = hit_ctrl ? wdata_i[4:0] : dev_q;
  assign frame  = build_frame(c45_q, kind, f_port, f_dev, wdata_i[15:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_skip_q <= 1'b0;
      c45_q      <= 1'b0;
      div_q      <= DIV_W'(DIV_RST);
      dev_q      <= '0;
      port_q     <= '0;
      data_q     <= '0;
      areg_q     <= '0;
    end else begin
      if (wr_ok && hit_stat) begin
        pre_skip_q <= wdata_i[5];
        c45_q      <= wdata_i[6];
        div_q      <= wdata_i[7 +: DIV_W];
      end
      if (wr_ok && hit_ctrl) begin
        dev_q  <= wdata_i[4:0];
        port_q <= wdata_i[9:5];
      end
      if (wr_ok && hit_addr) areg_q <= wdata_i[15:0];
      if (wr_ok && hit_data) data_q <= wdata_i[15:0];
      else if (done && !mdio_oe_o) data_q <= rd_word;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (1'b1)
      hit_stat: rdata_o = {16'h0, div_q, c45_q, pre_skip_q, 3'b000, rderr, busy};
      hit_ctrl: rdata_o = {22'h0, port_q, dev_q};
      hit_data: rdata_o = {16'h0, data_q};
      hit_addr: rdata_o = {16'h0, areg_q};
      default:  rdata_o = '0;
    endcase
  end

  mgmt_mdc_gen #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_mdc (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mgmt_frame_shifter #(.PRE_W(32), .FR_W(32), .DATA_W(16)) u_shift (
    .clk_i, .rst_ni, .start_i(start), .frame_i(frame), .rd_i(start_rd),
    .skip_pre_i(pre_skip_q), .rise_i(rise), .fall_i(fall), .mdio_i,
    .busy_o(busy), .mdo_o(mdio_o), .oe_o(mdio_oe_o), .rdata_o(rd_word),
    .rderr_o(rderr), .done_o(done)
  );

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && req_i && we_i) |=> ($stable(port_q) && $stable(dev_q) && $stable(div_q)
                                 && $stable(c45_q) && $stable(areg_q)));
  p_mdo_on_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !fall) |=> $stable(mdio_o));
  p_idle_mdc_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  p_c22_addr_no_frame_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && req_i && we_i && hit_addr && !c45_q) |=> !busy);
endmodule

// File: tb/mgmt_bus_master_bench.sv
module mgmt_bus_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [3:0] addr = 4'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic mdc, mdio_in = 1'b1, mdio_out, mdio_oe;

  int checks = 0, errors = 0;
  bit done_run = 0;

  // reference model state
  bit m_busy, m_rd, m_mdc, m_err, m_pre, m_c45;
  int m_cnt, m_idx, m_div;
  logic [63:0] m_bits;
  logic [15:0] m_rv, m_data, m_areg;
  logic [4:0] m_port, m_dev;
  bit phy_on = 1;
  logic [15:0] phy_word = '0;

  always #5 clk = ~clk;

  mgmt_bus_master u_mgmt_bus_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .mdc_o(mdc), .mdio_i(mdio_in),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  function automatic logic [63:0] ref_frame(bit c45, int kind, logic [4:0] p,
                                            logic [4:0] d, logic [15:0] v);
    logic [1:0] st, op, ta;
    st = c45 ? 2'd0 : 2'd1;
    if (kind == 0) op = 2'd0;
    else if (kind == 1) op = 2'd1;
    else op = c45 ? 2'd3 : 2'd2;
    ta = (kind == 2) ? 2'd3 : 2'd2;
    return {32'hFFFF_FFFF, st, op, p, d, ta, (kind == 2) ? 16'hFFFF : v};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_rd = 0; m_mdc = 0; m_err = 0; m_pre = 0; m_c45 = 0;
      m_cnt = 0; m_idx = 0; m_div = 5; m_bits = '0; m_rv = '0;
      m_data = '0; m_areg = '0; m_port = '0; m_dev = '0;
    end else begin
      bit b0;
      int ed;
      b0 = m_busy;
      ed = (m_div < 5) ? 5 : m_div;
      if (b0) begin
        if (m_cnt == 2 * ed) begin
          m_cnt = 0; m_mdc = 0;
          if (m_idx == 63) begin
            m_busy = 0;
            if (m_rd) m_data = m_rv;
          end else m_idx++;
        end else begin
          if (m_cnt == ed) begin
            m_mdc = 1;
            if (m_rd && m_idx == 47 && mdio_in) m_err = 1;
            if (m_rd && m_idx >= 48) m_rv = {m_rv[14:0], mdio_in};
          end
          m_cnt++;
        end
      end
      if (req && we && !b0) begin
        int kind;
        kind = -1;
        case (addr)
          4'd12: begin m_pre = wdata[5]; m_c45 = wdata[6]; m_div = int'(wdata[15:7]); end
          4'd13: begin
            m_dev = wdata[4:0]; m_port = wdata[9:5];
            if (wdata[15]) kind = 2;
          end
          4'd14: begin m_data = wdata[15:0]; kind = 1; end
          4'd15: begin m_areg = wdata[15:0]; if (m_c45) kind = 0; end
          default: ;
        endcase
        if (kind >= 0) begin
          m_bits = ref_frame(m_c45, kind, m_port, m_dev, wdata[15:0]);
          m_busy = 1; m_rd = (kind == 2); m_err = 0; m_rv = '0;
          m_cnt = 0; m_mdc = 0; m_idx = m_pre ? 32 : 0;
        end
      end
    end
  end

  always @(negedge clk)
    mdio_in <= (m_busy && m_rd && m_idx >= 47 && phy_on) ?
               ((m_idx == 47) ? 1'b0 : phy_word[63 - m_idx]) : 1'b1;

  // cycle compare of the serial side (R3 R5 R7 R8 R9 R11)
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      bit e_oe;
      e_oe = m_busy && !(m_rd && m_idx >= 46);
      checks++;
      if (mdc !== m_mdc) begin
        errors++;
        $display("FAIL R7 mdc at %0t: got %b exp %b", $time, mdc, m_mdc);
      end
      checks++;
      if (mdio_oe !== e_oe) begin
        errors++;
        $display("FAIL R5 output enable at %0t: got %b exp %b", $time, mdio_oe, e_oe);
      end
      if (e_oe) begin
        checks++;
        if (mdio_out !== m_bits[63 - m_idx]) begin
          errors++;
          $display("FAIL R3/R8/R11 mdio bit %0d at %0t: got %b exp %b",
                   m_idx, $time, mdio_out, m_bits[63 - m_idx]);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s word %0d: got %h exp %h", tag, a, rdata, exp);
    end
  endtask

  // polls busy at the ports; exp_cyc 0 skips the length checks
  task automatic wait_idle(input int exp_cyc, input int exp_rise, input string tag);
    int n, r;
    bit prev;
    n = 0; r = 0; prev = mdc;
    addr = 4'd12;
    #1;
    while (rdata[0]) begin
      n++;
      if (mdc && !prev) r++;
      prev = mdc;
      @(negedge clk);
      #1;
    end
    if (exp_cyc != 0) begin
      checks++;
      if (n != exp_cyc) begin
        errors++;
        $display("FAIL %s frame length: got %0d exp %0d", tag, n, exp_cyc);
      end
      checks++;
      if (r != exp_rise) begin
        errors++;
        $display("FAIL %s mdc pulses: got %0d exp %0d", tag, r, exp_rise);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(4'd12, 32'h280, "R1");
    chk(4'd13, 32'h0, "R1");
    chk(4'd14, 32'h0, "R1");
    chk(4'd15, 32'h0, "R1");

    wr(4'd13, 32'h71);
    chk(4'd13, 32'h71, "R2");
    chk(4'd12, 32'h280, "R2");

    // C22 write, then collide writes with the busy frame
    wr(4'd14, 32'hA5C3);
    chk(4'd12, 32'h281, "R3");
    wr(4'd13, 32'h83FF);
    wr(4'd14, 32'h1111);
    wr(4'd12, 32'h40);
    wr(4'd15, 32'h4444);
    wait_idle(0, 0, "R10");
    chk(4'd13, 32'h71, "R10");
    chk(4'd14, 32'hA5C3, "R10");
    chk(4'd12, 32'h280, "R10");
    chk(4'd15, 32'h0, "R10");

    wr(4'd15, 32'h1234);
    chk(4'd12, 32'h280, "R4");
    chk(4'd15, 32'h1234, "R4");

    wr(4'd12, 32'h3E0);
    chk(4'd12, 32'h3E0, "R2");
    wr(4'd15, 32'hBEEF);
    wait_idle(480, 32, "R4 R9");
    chk(4'd15, 32'hBEEF, "R4");

    phy_on = 1; phy_word = 16'h5A0F;
    wr(4'd13, 32'h80A3);
    wait_idle(480, 32, "R9 R11");
    chk(4'd14, 32'h5A0F, "R5 R11");
    chk(4'd12, 32'h3E0, "R6");
    chk(4'd13, 32'hA3, "R2");

    wr(4'd12, 32'h100);
    chk(4'd12, 32'h100, "R7");
    phy_on = 0;
    wr(4'd13, 32'h8071);
    wait_idle(704, 64, "R7");
    chk(4'd12, 32'h102, "R6");
    chk(4'd14, 32'hFFFF, "R6");

    phy_on = 1; phy_word = 16'h0F0F;
    wr(4'd13, 32'h8071);
    chk(4'd12, 32'h101, "R6");
    wait_idle(0, 0, "R5");
    chk(4'd14, 32'h0F0F, "R5");
    chk(4'd12, 32'h100, "R6");

    wr(4'd12, 32'h2C0);
    wr(4'd14, 32'h7777);
    wait_idle(704, 64, "R3 R11");
    chk(4'd14, 32'h7777, "R11");

    repeat (4) @(negedge clk);
    done_run = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule